// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block decides whether a phase-locked loop has settled. On every comparison cycle of the phase detector it measures the phase error as the high time of the up and down correction pulses. The high time is counted in periods of a sampling clock, and the longer of the two pulses is taken as that cycle's error. A strobe marks the end of each comparison cycle. At the strobe the error is sorted into one of three bands: small, middle or large. The two band edges are count thresholds that can be programmed at run time.

The lock flag is active high. It rises once enough consecutive small-error cycles have been seen. A select input sets the run length to short (3 cycles) or long (5 cycles). A single large-error cycle drops the flag. A middle-band cycle restarts the run without touching a flag that is already high, which gives the detector hysteresis between acquiring lock and losing it. A power-down input returns the detector to its unlocked state. Power-down covers a disabled chip as well as a programmed power-down.

Top module: `lock_monitor`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `lock_flag` is 0. A 1 on `lock_flag` means locked.
- R2: The error of a cycle is the larger of two counts: the sampling-clock edges at which `up_pulse` was high, and those at which `dn_pulse` was high, since the previous strobe edge. Each count stops at 2^CNT_W-1.
- R3: With `long_run` = 0, `lock_flag` becomes 1 at the strobe edge that completes 3 consecutive small cycles. A small cycle is one whose error is less than `lock_thr`.
- R4: With `long_run` = 1, `lock_flag` becomes 1 at the strobe edge that completes 5 consecutive small cycles.
- R5: A large cycle clears `lock_flag` and the run count at its strobe edge. A large cycle is one whose error is greater than `unlock_thr`. The large band takes priority over the small band if the two thresholds overlap.
- R6: A middle cycle clears the run count and leaves `lock_flag` unchanged. A middle cycle is one that is neither small nor large.
- R7: If `up_pulse` or `dn_pulse` is high on the strobe cycle itself, the cycle is large, whatever the counts are.
- R8: At a clock edge where `pwr_dn` is 1, the flag, the run count and both width counts are cleared. This takes priority over a strobe on the same edge.
- R9: `lock_flag` changes only at a clock edge where `cyc_strobe` or `pwr_dn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down, synchronous clear of all state |
| up_pulse | input | 1 | Phase detector up correction pulse |
| dn_pulse | input | 1 | Phase detector down correction pulse |
| cyc_strobe | input | 1 | One-clock marker at the end of each comparison cycle |
| long_run | input | 1 | Run length select: 0 = 3 cycles, 1 = 5 cycles |
| lock_thr | input | CNT_W | Small-error bound (error < lock_thr) |
| unlock_thr | input | CNT_W | Large-error bound (error > unlock_thr) |
| lock_flag | output | 1 | Lock indication, active high |

## Verification
Two of the block's functions can land on the same clock edge.

The first pair is power-down and a strobe. The bench locks the detector, then raises `pwr_dn` together with a strobe whose cycle is small. It judges the result by `lock_flag` reading 0 afterwards. It then shows that the width counts were also cleared: a long pulse is applied before a power-down, and the next pulse-free cycle is classified as small.

The second pair is a strobe and a correction pulse that is still high. The bench keeps a short pulse high into the strobe cycle and expects the flag to drop, even though the count alone is below both thresholds.

Sweeps over the pulse width, across both run lengths, judge every strobe against an arithmetic model of the run count and flag.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

   // Band of one comparison cycle's phase error
   typedef enum logic [1:0] {
      ERR_SMALL = 2'd0,
      ERR_MID   = 2'd1,
      ERR_LARGE = 2'd2
   } err_class_e;

endpackage

// File: rtl/pulse_width_meter.sv
// Counts sampling-clock edges with the pulse high since the last strobe edge.
module pulse_width_meter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe,
   input  logic             pulse_in,
   output logic [CNT_W-1:0] width
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width <= '0;
      end else if (clr || strobe) begin
         width <= '0;
      end else if (pulse_in && (width != CNT_MAX)) begin
         width <= width + 1'b1;
      end
   end
endmodule

// File: rtl/error_classifier.sv
// Sorts one cycle's error into small / middle / large.
module error_classifier
   import lockdet_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int N_CH  = 2
) (
   input  logic [N_CH-1:0][CNT_W-1:0] widths,
   input  logic [N_CH-1:0]            live,
   input  logic [CNT_W-1:0]           lock_thr,
   input  logic [CNT_W-1:0]           unlock_thr,
   output err_class_e                 cls
);
   logic [CNT_W-1:0] err_max;

   always_comb begin
      err_max = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (widths[i] > err_max) err_max = widths[i];
      end
   end

   always_comb begin
      if ((|live) || (err_max > unlock_thr)) cls = ERR_LARGE;
      else if (err_max < lock_thr)          cls = ERR_SMALL;
      else                                  cls = ERR_MID;
   end
endmodule

// File: rtl/run_tracker.sv
// Consecutive small-cycle counter and lock flag with hysteresis.
module run_tracker
   import lockdet_pkg::*;
#(
   parameter int RUN_SHORT = 3,
   parameter int RUN_LONG  = 5,
   parameter int RUN_W     = $clog2(RUN_LONG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe,
   input  logic             long_run,
   input  err_class_e       cls,
   output logic [RUN_W-1:0] run_cnt,
   output logic             lock_flag
);
   logic [RUN_W-1:0] need;
   logic [RUN_W-1:0] run_inc;

   assign need    = long_run ? RUN_W'(RUN_LONG) : RUN_W'(RUN_SHORT);
   assign run_inc = (run_cnt < need) ? run_cnt + 1'b1 : run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         lock_flag <= 1'b0;
      end else if (clr) begin
         run_cnt   <= '0;
         lock_flag <= 1'b0;
      end else if (strobe) begin
         unique case (cls)
            ERR_SMALL: begin
               run_cnt   <= run_inc;
               lock_flag <= lock_flag | (run_inc >= need);
            end
            ERR_MID: begin
               run_cnt   <= '0;
            end
            default: begin
               run_cnt   <= '0;
               lock_flag <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
   import lockdet_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int RUN_SHORT = 3,
   parameter int RUN_LONG  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn,
   input  logic             up_pulse,
   input  logic             dn_pulse,
   input  logic             cyc_strobe,
   input  logic             long_run,
   input  logic [CNT_W-1:0] lock_thr,
   input  logic [CNT_W-1:0] unlock_thr,
   output logic             lock_flag
);
   localparam int N_CH  = 2;
   localparam int RUN_W = $clog2(RUN_LONG + 1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (RUN_SHORT < 1 || RUN_LONG < RUN_SHORT) begin : g_bad_run
      $error("run lengths must satisfy 1 <= RUN_SHORT <= RUN_LONG");
   end

   logic [N_CH-1:0]            pulses;
   logic [N_CH-1:0][CNT_W-1:0] widths;
   err_class_e                 cls;
   logic [RUN_W-1:0]           run_cnt;

   assign pulses = {dn_pulse, up_pulse};

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_meter
      pulse_width_meter #(.CNT_W(CNT_W)) u_meter (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (pwr_dn),
         .strobe   (cyc_strobe),
         .pulse_in (pulses[ch]),
         .width    (widths[ch])
      );
   end

   error_classifier #(.CNT_W(CNT_W), .N_CH(N_CH)) u_class (
      .widths     (widths),
      .live       (pulses),
      .lock_thr   (lock_thr),
      .unlock_thr (unlock_thr),
      .cls        (cls)
   );

   run_tracker #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG), .RUN_W(RUN_W)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (pwr_dn),
      .strobe    (cyc_strobe),
      .long_run  (long_run),
      .cls       (cls),
      .run_cnt   (run_cnt),
      .lock_flag (lock_flag)
   );
endmodule

// File: rtl/lock_monitor_chk.sv
module lock_monitor_chk #(
   parameter int RUN_LONG = 5,
   parameter int RUN_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_dn,
   input logic             up_pulse,
   input logic             dn_pulse,
   input logic             cyc_strobe,
   input logic             lock_flag,
   input logic [RUN_W-1:0] run_cnt
);
   p_pdn_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (!lock_flag && run_cnt == '0));

   p_rise_at_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_flag) |-> ($past(cyc_strobe) && !$past(pwr_dn)));

   p_live_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_strobe && (up_pulse || dn_pulse)) |=> !lock_flag);

   p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_strobe && !pwr_dn) |=> $stable(lock_flag));

   p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= RUN_W'(RUN_LONG));
endmodule

bind lock_monitor lock_monitor_chk #(.RUN_LONG(RUN_LONG), .RUN_W(RUN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_dn     (pwr_dn),
   .up_pulse   (up_pulse),
   .dn_pulse   (dn_pulse),
   .cyc_strobe (cyc_strobe),
   .lock_flag  (lock_flag),
   .run_cnt    (run_cnt)
);

// File: tb/lock_monitor_test.sv
`timescale 1ns/1ps
module lock_monitor_test;
   localparam int CNT_W = 8;
   localparam int CMAX  = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0;
   logic up_pulse = 1'b0;
   logic dn_pulse = 1'b0;
   logic cyc_strobe = 1'b0;
   logic long_run = 1'b0;
   logic [CNT_W-1:0] lock_thr = 8'd3;
   logic [CNT_W-1:0] unlock_thr = 8'd5;
   logic lock_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model
   int m_run = 0;
   bit m_flag = 1'b0;

   always #10 clk = ~clk;

   lock_monitor #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .up_pulse(up_pulse),
      .dn_pulse(dn_pulse), .cyc_strobe(cyc_strobe), .long_run(long_run),
      .lock_thr(lock_thr), .unlock_thr(unlock_thr), .lock_flag(lock_flag)
   );

   task automatic check(string req, bit act, bit exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: lock_flag=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int cls_of(int err, bit live);
      int e = (err > CMAX) ? CMAX : err;
      if (live || e > int'(unlock_thr)) return 2;
      if (e < int'(lock_thr)) return 0;
      return 1;
   endfunction

   task automatic model_step(int c);
      int need = long_run ? 5 : 3;
      if (c == 0) begin
         if (m_run < need) m_run++;
         if (m_run >= need) m_flag = 1'b1;
      end else if (c == 1) begin
         m_run = 0;
      end else begin
         m_run = 0;
         m_flag = 1'b0;
      end
   endtask

   task automatic do_pdn();
      @(negedge clk) pwr_dn = 1'b1;
      @(negedge clk) pwr_dn = 1'b0;
      m_run = 0;
      m_flag = 1'b0;
      check("R8", lock_flag, 1'b0);
   endtask

   // One comparison cycle; tag "" picks the requirement from the band
   task automatic pd_cycle(int up_w, int dn_w, bit live, string tag);
      int mx = (up_w > dn_w) ? up_w : dn_w;
      int c;
      string t;
      for (int k = 0; k < mx; k++) begin
         @(negedge clk);
         up_pulse = (k < up_w);
         dn_pulse = (k < dn_w);
      end
      @(negedge clk);
      check("R9", lock_flag, m_flag);
      up_pulse = live;
      dn_pulse = 1'b0;
      cyc_strobe = 1'b1;
      @(negedge clk);
      cyc_strobe = 1'b0;
      up_pulse = 1'b0;
      c = cls_of(mx, live);
      model_step(c);
      if (tag != "") t = tag;
      else if (live) t = "R7";
      else if (c == 0) t = long_run ? "R4" : "R3";
      else if (c == 1) t = "R6";
      else t = "R5";
      check(t, lock_flag, m_flag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", lock_flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", lock_flag, 1'b0);

      // sweep of run length and pulse width over all three bands
      for (int p = 0; p < 2; p++) begin
         long_run = p[0];
         for (int w = 0; w <= 8; w++) begin
            do_pdn();
            pd_cycle(1, 0, 1'b0, "");
            pd_cycle(0, 1, 1'b0, "");
            pd_cycle(0, w, 1'b0, "");
            for (int k = 0; k < 5; k++) pd_cycle(1, 2, 1'b0, "");
            pd_cycle(w, w / 2, 1'b0, "");
            pd_cycle(0, 0, 1'b0, "");
            pd_cycle(w / 3, w, 1'b0, "R2");
         end
      end

      // R7: short pulse still high on the strobe cycle
      long_run = 1'b0;
      do_pdn();
      for (int k = 0; k < 3; k++) pd_cycle(1, 0, 1'b0, "");
      check("R3", lock_flag, 1'b1);
      pd_cycle(1, 0, 1'b1, "R7");

      // R8: power-down on the same edge as a lock-completing strobe
      for (int k = 0; k < 3; k++) pd_cycle(0, 1, 1'b0, "");
      for (int k = 0; k < 2; k++) pd_cycle(1, 1, 1'b0, "");
      @(negedge clk);
      pwr_dn = 1'b1;
      cyc_strobe = 1'b1;
      @(negedge clk);
      pwr_dn = 1'b0;
      cyc_strobe = 1'b0;
      m_run = 0;
      m_flag = 1'b0;
      check("R8", lock_flag, 1'b0);

      // R8: width counts cleared by power-down
      lock_thr = 8'd2;
      unlock_thr = 8'd4;
      pd_cycle(0, 0, 1'b0, "");
      pd_cycle(0, 0, 1'b0, "");
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         up_pulse = 1'b1;
      end
      @(negedge clk);
      up_pulse = 1'b0;
      pwr_dn = 1'b1;
      @(negedge clk);
      pwr_dn = 1'b0;
      m_run = 0;
      m_flag = 1'b0;
      for (int k = 0; k < 3; k++) pd_cycle(0, 0, 1'b0, "R8");

      // R5: overlapping thresholds, large wins
      lock_thr = 8'd9;
      unlock_thr = 8'd4;
      pd_cycle(6, 0, 1'b0, "R5");

      // R2: saturation of the width count
      lock_thr = 8'd255;
      unlock_thr = 8'd255;
      do_pdn();
      pd_cycle(1, 0, 1'b0, "");
      pd_cycle(0, 1, 1'b0, "");
      pd_cycle(300, 0, 1'b0, "R2");
      pd_cycle(1, 0, 1'b0, "R2");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule